// File: doc/BRIEF.md
# Split-Array SAR Switching Controller

This block sequences one channel of a successive-approximation converter whose feedback DAC is a split capacitor array. In that array the largest binary capacitor is replaced by a full copy of the remaining binary array, the upper subarray, which sits in parallel with the lower (main) subarray on the shared top plate. Each subarray holds `NBITS-1` binary capacitors of weight 2^k, for k from 0 to NBITS-2, plus a unit termination capacitor that is never switched. The upper subarray's termination stays on the reference and the main subarray's termination stays on ground.

A `start` request puts every switched bottom plate on the input path for as long as `start` is held. When `start` drops, the block loads the first trial. From then on, each accepted comparator decision settles one code bit, MSB first. A high decision raises one main-subarray capacitor to the reference. A low decision drops the capacitor of the same weight in the upper subarray to ground. Each bit-cycle therefore moves exactly one bottom plate, so the DAC never makes a transient step in the wrong direction because two switch drivers are skewed. The LSB decision moves nothing and completes the code.

Top module: `split_sar_ctrl`

## Requirements
- R1: In the first cycle after sampling ends, `hi_sw` is all ones (upper subarray on the reference), `lo_sw` is all zeros (main subarray on ground), `sampling` is 0 and `code` is 0. Switch bit k drives the capacitor of weight 2^k, and a 1 means the bottom plate is on the reference.
- R2: A decision of 1 (input at or above the current trial) for bit b > 0 sets `code[b]` and `lo_sw[b-1]`, and leaves `hi_sw` unchanged.
- R3: A decision of 0 for bit b > 0 clears `code[b]` and `hi_sw[b-1]`, and leaves `lo_sw` unchanged.
- R4: The combined vector {`lo_sw`,`hi_sw`} changes in exactly one bit on each accepted decision for bits NBITS-1 down to 1, and in no bit on the LSB decision.
- R5: Bits are resolved MSB first, one per accepted strobe. With an ideal comparator the final code equals the input level clamped to 0..2^NBITS-1. When `done` is high, `lo_sw` and `hi_sw` both equal `code[NBITS-1:1]`.
- R6: `done` is high for exactly one cycle, starting at the clock edge that accepts the LSB decision.
- R7: `cmp_valid` has no effect outside a conversion. During a conversion, a cycle with `cmp_valid` low changes no output.
- R8: While `start` is high, at any point including in the middle of a conversion, the next edge sets `sampling` to 1 and clears `code` and both switch vectors. These values hold for as long as `start` stays high.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit-cycle per accepted decision |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample request; the conversion begins when it falls |
| cmp_valid | input | 1 | Comparator result strobe |
| cmp_hi | input | 1 | Comparator result: 1 means the input is at or above the trial level |
| sampling | output | 1 | Bottom plates are on the input path |
| lo_sw | output | NBITS-1 | Main subarray switch controls, 1 = reference |
| hi_sw | output | NBITS-1 | Upper subarray switch controls, 1 = reference |
| code | output | NBITS | Resolved code |
| done | output | 1 | One-cycle pulse when the code is complete |

## Verification
A wrong bit pointer or a wrong select mask moves a capacitor of the wrong weight. The bench sees this at the very next decision as a switch bit other than the expected one changing, or as two switch bits changing at once. Because the bench drives a comparator model that decides from the port-visible switch vectors, a single bad trial level carries into the remaining bits and shows as a wrong final code by the `done` pulse. A pointer that fails to stop at the LSB shows as a missing or stretched `done`, or as a switch that moves on the final decision.

// File: rtl/split_sar_ctrl.sv
module split_sar_ctrl #(
  parameter int NBITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_valid,
  input  logic             cmp_hi,
  output logic             sampling,
  output logic [NBITS-2:0] lo_sw,
  output logic [NBITS-2:0] hi_sw,
  output logic [NBITS-1:0] code,
  output logic             done
);
  localparam int SW = NBITS - 1;
  localparam int PW = $clog2(NBITS);

  logic          busy;
  logic [PW-1:0] ptr;
  logic [SW-1:0] sel;
  logic          take;

  assign take = busy && cmp_valid && !start;
  assign sel  = (ptr == '0) ? '0 : (SW'(1) << (ptr - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampling <= 1'b0;
      busy     <= 1'b0;
      ptr      <= '0;
      lo_sw    <= '0;
      hi_sw    <= '0;
      code     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sampling <= 1'b1;
        busy     <= 1'b0;
        lo_sw    <= '0;
        hi_sw    <= '0;
        code     <= '0;
      end else if (sampling) begin
        sampling <= 1'b0;
        busy     <= 1'b1;
        ptr      <= PW'(NBITS - 1);
        hi_sw    <= '1;
      end else if (take) begin
        code[ptr] <= cmp_hi;
        if (cmp_hi) lo_sw <= lo_sw | sel;
        else        hi_sw <= hi_sw & ~sel;
        if (ptr == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr - 1'b1;
        end
      end
    end
  end

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sampling) && !start |-> (hi_sw == '1) && (lo_sw == '0) && (code == '0)); // R1

  AST_UP_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmp_hi |=> $stable(hi_sw)); // R2

  AST_DOWN_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cmp_hi |=> $stable(lo_sw)); // R3

  AST_ONE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && (ptr != '0) |=> $countones({lo_sw, hi_sw} ^ $past({lo_sw, hi_sw})) == 1); // R4

  AST_LSB_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    take && (ptr == '0) |=> $stable({lo_sw, hi_sw})); // R4

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lo_sw == code[NBITS-1:1]) && (hi_sw == code[NBITS-1:1])); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !sampling && !start |=> $stable(code) && $stable(lo_sw) && $stable(hi_sw)); // R7

  AST_SAMPLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sampling && (lo_sw == '0) && (hi_sw == '0) && (code == '0)); // R8
endmodule

// File: tb/split_sar_ctrl_test.sv
module split_sar_ctrl_test;
  localparam int NBITS = 5;
  localparam int SW    = NBITS - 1;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int TBL [ROWS][3] = '{
    '{0, 0, 0}, '{31, 31, 0}, '{16, 16, 1}, '{15, 15, 0},
    '{1, 1, 2}, '{21, 21, 0}, '{40, 31, 1}, '{-3, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_valid = 1'b0;
  logic cmp_hi = 1'b0;
  logic sampling;
  logic [SW-1:0] lo_sw, hi_sw;
  logic [NBITS-1:0] code;
  logic done;

  int checks = 0;
  int failures = 0;

  split_sar_ctrl #(.NBITS(NBITS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_valid(cmp_valid),
    .cmp_hi(cmp_hi), .sampling(sampling), .lo_sw(lo_sw), .hi_sw(hi_sw),
    .code(code), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int trial();
    int t = 1;
    for (int k = 0; k < SW; k++) t += (int'(lo_sw[k]) + int'(hi_sw[k])) << k;
    return t;
  endfunction

  function automatic int hamming(input logic [2*SW-1:0] a, input logic [2*SW-1:0] b);
    return $countones(a ^ b);
  endfunction

  task automatic begin_sample(input int hold);
    @(negedge clk) start = 1'b1;
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      chk(sampling && lo_sw == '0 && hi_sw == '0, "R8 hold", int'(sampling), 1);
    end
    @(negedge clk) start = 1'b0;
    chk(sampling && lo_sw == '0 && hi_sw == '0 && code == '0, "R8 sample", int'({lo_sw, hi_sw}), 0);
    @(negedge clk);
    chk(hi_sw == '1 && lo_sw == '0 && !sampling && code == '0, "R1 first trial", int'(hi_sw), (1 << SW) - 1);
  endtask

  task automatic decide(input int vin, input int b, input int gap);
    logic [2*SW-1:0] prev;
    logic [SW-1:0] plo, phi;
    logic up;
    for (int g = 0; g < gap; g++) begin
      prev = {lo_sw, hi_sw};
      @(negedge clk);
      chk({lo_sw, hi_sw} == prev && !done, "R7 no strobe", int'({lo_sw, hi_sw}), int'(prev));
    end
    prev = {lo_sw, hi_sw};
    plo = lo_sw;
    phi = hi_sw;
    up = (vin >= trial());
    cmp_valid = 1'b1;
    cmp_hi = up;
    @(negedge clk) cmp_valid = 1'b0;
    chk(code[b] == up, "R5 bit", int'(code[b]), int'(up));
    if (b > 0) begin
      chk(hamming(prev, {lo_sw, hi_sw}) == 1, "R4 one toggle", hamming(prev, {lo_sw, hi_sw}), 1);
      if (up) chk(hi_sw == phi && lo_sw[b-1] == 1'b1, "R2 up", int'(lo_sw), int'(plo | (SW'(1) << (b-1))));
      else    chk(lo_sw == plo && hi_sw[b-1] == 1'b0, "R3 down", int'(hi_sw), int'(phi & ~(SW'(1) << (b-1))));
      chk(!done, "R6 early", int'(done), 0);
    end else begin
      chk(hamming(prev, {lo_sw, hi_sw}) == 0, "R4 lsb still", hamming(prev, {lo_sw, hi_sw}), 0);
      chk(done, "R6 done", int'(done), 1);
    end
  endtask

  task automatic run_conv(input int vin, input int expc, input int gap);
    begin_sample(1);
    for (int b = NBITS - 1; b >= 0; b--) decide(vin, b, gap);
    chk(code == expc, "R5 code", int'(code), expc);
    chk(lo_sw == code[NBITS-1:1] && hi_sw == code[NBITS-1:1], "R5 final switches", int'(lo_sw), int'(code[NBITS-1:1]));
    @(negedge clk);
    chk(!done, "R6 pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sampling && lo_sw == '0 && hi_sw == '0 && code == '0 && !done, "R9 reset", int'({lo_sw, hi_sw, code}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b1;
    cmp_hi = 1'b1;
    repeat (3) @(negedge clk);
    cmp_valid = 1'b0;
    chk(code == '0 && lo_sw == '0 && hi_sw == '0 && !done, "R7 idle strobe", int'(code), 0);

    for (int r = 0; r < ROWS; r++) run_conv(TBL[r][0], TBL[r][1], TBL[r][2]);

    cmp_valid = 1'b1;
    cmp_hi = 1'b0;
    repeat (2) @(negedge clk);
    cmp_valid = 1'b0;
    chk(code == 5'd0 && !done, "R7 after done", int'(code), 0);

    begin_sample(1);
    decide(9, NBITS - 1, 0);
    decide(9, NBITS - 2, 0);
    begin_sample(3);
    for (int b = NBITS - 1; b >= 0; b--) decide(26, b, 0);
    chk(code == 26, "R8 restart code", int'(code), 26);
    @(negedge clk);
    chk(!done, "R6 restart pulse", int'(done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule